// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Sequencer

This block sits on the host side of a word-wide parallel NOR flash. It owns the chip-enable, write-enable and output-enable strobes, the address bus and the bidirectional data bus. It accepts one request at a time over a valid/ready handshake: program one word, erase a small sector, erase a larger block, or erase the whole chip. For each request it plays out the fixed unlock and command write cycles that the flash expects. It then polls the device with status reads until the internal operation ends, and reports completion or timeout with a one-cycle done pulse.

Every bus cycle is built by a small timing engine with parameterised setup, strobe-low and hold lengths. The address and the write data are driven before the write strobe falls and held until after it rises. A write never lowers the output enable, and a read never drives the data bus. The device is idle when bit 6 of its status word stops changing, so the block declares completion once two consecutive status reads agree on that bit. If no such pair arrives within a parameterised number of reads, the operation ends as a timeout.

Top module: `nor_seq_top`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `flash_ce_n`, `flash_we_n` and `flash_oe_n` are 1, `flash_dq_oe` is 0 and `done_valid` is 0.
- R2: A request with `req_op` = 0 (program) produces exactly four write cycles, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (`req_addr`, `req_data`).
- R3: Erase requests produce exactly six write cycles. The first five are (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h). The sixth is (`req_addr`, 30h) for `req_op` = 1 (sector), (`req_addr`, 50h) for `req_op` = 2 (block) and (5555h, 10h) for `req_op` = 3 (chip).
- R4: In every write cycle `flash_we_n` is low for exactly T_PULSE clocks. `flash_ce_n` is already low in the cycle before `flash_we_n` falls. Address and data keep their values for the whole time `flash_we_n` is low. `flash_oe_n` stays high and `flash_dq_oe` stays 1 throughout.
- R5: Status reads drive `flash_ce_n` and `flash_oe_n` low together, with `flash_we_n` high and `flash_dq_oe` 0.
- R6: After the last write, the block issues status reads with `flash_ce_n` high for at least POLL_GAP clocks before each one. It ends with a one-cycle `done_valid` and `done_timeout` = 0 after the first read whose bit 6 equals bit 6 of the read before it.
- R7: If MAX_POLLS status reads pass without such a match, the block ends with a one-cycle `done_valid` and `done_timeout` = 1, and issues no further read.
- R8: `req_ready` is 0 from the cycle after a request is accepted until after `done_valid`. A request held while `req_ready` is 0 is not accepted and causes no bus cycle.
- R9: No write cycle occurs once status polling has begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | ADDR_W | Word address or sector/block address |
| req_data | input | DATA_W | Word to program |
| done_valid | output | 1 | One-cycle completion pulse |
| done_timeout | output | 1 | Completion was a poll timeout (valid with done_valid) |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_addr | output | ADDR_W | Flash word address |
| flash_dq_out | output | DATA_W | Data driven toward the flash |
| flash_dq_oe | output | 1 | Enable for the data bus driver |
| flash_dq_in | input | DATA_W | Data returned by the flash |

## Verification
The bench builds the block with T_SETUP = 2, T_PULSE = 3, T_HOLD = 1, T_READ = 2, POLL_GAP = 3 and MAX_POLLS = 6. With these values every strobe width and every CE-high gap can be measured on a handful of clocks. The small poll limit lets a flash model that stays busy for 20 reads reach the timeout path, and other busy lengths of 0 to 4 reads end in a match on the last permitted read or earlier. Each busy length is paired with a final data bit 6 of either value, so both the toggling phase and the first-read-after-busy coincidence decide the read count.

// File: rtl/nor_seq_pkg.sv
// Package: shared types and command constants for the NOR flash sequencer.
// Assumes a 16-bit-or-wider command space; unlock addresses are zero-extended.
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_BLOCK = 2'd2,
        OP_CHIP  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACT,
        PH_HOLD
    } phase_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR,
        S_WR_WAIT,
        S_GAP,
        S_RD,
        S_RD_WAIT,
        S_FIN
    } seq_e;

    localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_FIRST     = 8'hAA;
    localparam logic [7:0]  KEY_SECOND    = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM   = 8'hA0;
    localparam logic [7:0]  CMD_ERASE_PRE = 8'h80;
    localparam logic [7:0]  CMD_SECT_ERS  = 8'h30;
    localparam logic [7:0]  CMD_BLOCK_ERS = 8'h50;
    localparam logic [7:0]  CMD_CHIP_ERS  = 8'h10;

    localparam int unsigned STAT_TOGGLE_BIT = 6;

endpackage

// File: rtl/nor_cmd_gen.sv
// Module: nor_cmd_gen
// Maps (operation, step index) to the address/data of one command write cycle
// and flags the final step. Purely combinational; assumes ADDR_W >= 16 and
// DATA_W >= 8. Program uses steps 0..3, erases use steps 0..5.
module nor_cmd_gen
    import nor_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 16
) (
    input  op_e               op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_data,
    output logic              cyc_last
);
    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNLOCK_ADDR_A);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(UNLOCK_ADDR_B);
    localparam logic [2:0] PROG_LAST  = 3'd3;
    localparam logic [2:0] ERASE_LAST = 3'd5;

    logic is_prog;
    assign is_prog = (op == OP_PROG);

    // Final-step detection depends on the length of the chosen sequence.
    always_comb begin : last_sel
        cyc_last = is_prog ? (step == PROG_LAST) : (step == ERASE_LAST);
    end

    // Address/data table for each step of the unlock and command sequence.
    always_comb begin : step_table
        cyc_addr = ADR_A;
        cyc_data = DATA_W'(KEY_FIRST);
        case (step)
            3'd0: begin
                cyc_addr = ADR_A;
                cyc_data = DATA_W'(KEY_FIRST);
            end
            3'd1: begin
                cyc_addr = ADR_B;
                cyc_data = DATA_W'(KEY_SECOND);
            end
            3'd2: begin
                cyc_addr = ADR_A;
                cyc_data = is_prog ? DATA_W'(CMD_PROGRAM) : DATA_W'(CMD_ERASE_PRE);
            end
            3'd3: begin
                cyc_addr = is_prog ? tgt_addr : ADR_A;
                cyc_data = is_prog ? tgt_data : DATA_W'(KEY_FIRST);
            end
            3'd4: begin
                cyc_addr = ADR_B;
                cyc_data = DATA_W'(KEY_SECOND);
            end
            default: begin
                case (op)
                    OP_SECT: begin
                        cyc_addr = tgt_addr;
                        cyc_data = DATA_W'(CMD_SECT_ERS);
                    end
                    OP_BLOCK: begin
                        cyc_addr = tgt_addr;
                        cyc_data = DATA_W'(CMD_BLOCK_ERS);
                    end
                    OP_CHIP: begin
                        cyc_addr = ADR_A;
                        cyc_data = DATA_W'(CMD_CHIP_ERS);
                    end
                    default: begin
                        cyc_addr = tgt_addr;
                        cyc_data = tgt_data;
                    end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/nor_bus_cycle.sv
// Module: nor_bus_cycle
// Runs one flash bus cycle (write or read) per start pulse: SETUP with CE low,
// ACT with WE or OE low, HOLD with CE low, then back to IDLE with CE high for
// at least one clock. Address and write data are latched at start and held
// for the whole cycle. Assumes every timing parameter is at least 1 and that
// start only arrives while the engine is idle.
module nor_bus_cycle
    import nor_seq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 19,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned T_SETUP = 2,
    parameter int unsigned T_PULSE = 4,
    parameter int unsigned T_HOLD  = 2,
    parameter int unsigned T_READ  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din
);
    localparam int unsigned CNT_W = $clog2(T_SETUP + T_PULSE + T_HOLD + T_READ + 1);
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(T_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(T_PULSE - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(T_HOLD - 1);
    localparam logic [CNT_W-1:0] LD_READ  = CNT_W'(T_READ - 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             rd_q;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);

    // Phase sequencing, per-phase countdown and capture of read data.
    always_ff @(posedge clk) begin : phase_seq
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            rd_q     <= 1'b0;
            bus_addr <= '0;
            bus_dout <= '0;
            rdata    <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_SETUP;
                        cnt      <= LD_SETUP;
                        rd_q     <= is_read;
                        bus_addr <= addr_in;
                        bus_dout <= data_in;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        phase <= PH_ACT;
                        cnt   <= rd_q ? LD_READ : LD_PULSE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_ACT: begin
                    if (cnt_zero) begin
                        phase <= PH_HOLD;
                        cnt   <= LD_HOLD;
                        if (rd_q) begin
                            rdata <= bus_din;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt_zero) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // Strobe and driver-enable decode from the registered phase.
    always_comb begin : strobe_decode
        ce_n    = (phase == PH_IDLE);
        we_n    = !((phase == PH_ACT) && !rd_q);
        oe_n    = !((phase == PH_ACT) && rd_q);
        bus_doe = (phase != PH_IDLE) && !rd_q;
        done    = (phase == PH_HOLD) && cnt_zero;
    end

endmodule

// File: rtl/nor_seq_top.sv
// Module: nor_seq_top
// Host-side program/erase sequencer for a word-wide parallel NOR flash.
// Accepts one request over valid/ready, issues the unlock and command writes
// through nor_bus_cycle, then polls status reads separated by POLL_GAP idle
// clocks until bit 6 repeats on two consecutive reads (done) or MAX_POLLS
// reads have passed (timeout). Assumes ADDR_W >= 16, DATA_W >= 8 and all
// timing parameters >= 1.
module nor_seq_top
    import nor_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned T_SETUP   = 2,
    parameter int unsigned T_PULSE   = 4,
    parameter int unsigned T_HOLD    = 2,
    parameter int unsigned T_READ    = 3,
    parameter int unsigned POLL_GAP  = 8,
    parameter int unsigned MAX_POLLS = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              done_valid,
    output logic              done_timeout,
    output logic              flash_ce_n,
    output logic              flash_we_n,
    output logic              flash_oe_n,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [DATA_W-1:0] flash_dq_out,
    output logic              flash_dq_oe,
    input  logic [DATA_W-1:0] flash_dq_in
);
    localparam int unsigned GAP_W  = $clog2(POLL_GAP + 1);
    localparam int unsigned POLL_W = $clog2(MAX_POLLS + 1);
    localparam logic [GAP_W-1:0]  GAP_LOAD  = GAP_W'(POLL_GAP - 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);

    seq_e              st;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [2:0]        step_q;
    logic [GAP_W-1:0]  gap_cnt;
    logic [POLL_W-1:0] poll_cnt;
    logic              prev_tgl;
    logic              have_prev;
    logic              tmo_q;

    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_data;
    logic              cyc_last;
    logic              eng_start;
    logic              eng_read;
    logic              eng_done;
    logic [DATA_W-1:0] eng_rdata;
    logic              cur_tgl;
    logic              stat_unused;

    nor_cmd_gen #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cmd (
        .op       (op_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .cyc_addr (cyc_addr),
        .cyc_data (cyc_data),
        .cyc_last (cyc_last)
    );

    nor_bus_cycle #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .T_SETUP (T_SETUP),
        .T_PULSE (T_PULSE),
        .T_HOLD  (T_HOLD),
        .T_READ  (T_READ)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .is_read  (eng_read),
        .addr_in  (eng_read ? addr_q : cyc_addr),
        .data_in  (cyc_data),
        .done     (eng_done),
        .rdata    (eng_rdata),
        .ce_n     (flash_ce_n),
        .we_n     (flash_we_n),
        .oe_n     (flash_oe_n),
        .bus_addr (flash_addr),
        .bus_dout (flash_dq_out),
        .bus_doe  (flash_dq_oe),
        .bus_din  (flash_dq_in)
    );

    assign cur_tgl     = eng_rdata[STAT_TOGGLE_BIT];
    assign stat_unused = ^{eng_rdata[DATA_W-1:STAT_TOGGLE_BIT+1],
                           eng_rdata[STAT_TOGGLE_BIT-1:0]};

    // Handshake, engine kick-off and done decode from the sequencer state.
    always_comb begin : ctl_decode
        req_ready    = (st == S_IDLE);
        eng_start    = (st == S_WR) || (st == S_RD);
        eng_read     = (st == S_RD);
        done_valid   = (st == S_FIN);
        done_timeout = (st == S_FIN) && tmo_q;
    end

    // Main sequencer: accept, command writes, poll gap, status reads, finish.
    always_ff @(posedge clk) begin : seq_fsm
        if (!rst_n) begin
            st        <= S_IDLE;
            op_q      <= OP_PROG;
            addr_q    <= '0;
            data_q    <= '0;
            step_q    <= '0;
            gap_cnt   <= '0;
            poll_cnt  <= '0;
            prev_tgl  <= 1'b0;
            have_prev <= 1'b0;
            tmo_q     <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q   <= op_e'(req_op);
                        addr_q <= req_addr;
                        data_q <= req_data;
                        step_q <= '0;
                        tmo_q  <= 1'b0;
                        st     <= S_WR;
                    end
                end
                S_WR: begin
                    st <= S_WR_WAIT;
                end
                S_WR_WAIT: begin
                    if (eng_done) begin
                        if (cyc_last) begin
                            have_prev <= 1'b0;
                            poll_cnt  <= '0;
                            gap_cnt   <= GAP_LOAD;
                            st        <= S_GAP;
                        end else begin
                            step_q <= step_q + 1'b1;
                            st     <= S_WR;
                        end
                    end
                end
                S_GAP: begin
                    if (gap_cnt == '0) begin
                        st <= S_RD;
                    end else begin
                        gap_cnt <= gap_cnt - 1'b1;
                    end
                end
                S_RD: begin
                    st <= S_RD_WAIT;
                end
                S_RD_WAIT: begin
                    if (eng_done) begin
                        poll_cnt  <= poll_cnt + 1'b1;
                        prev_tgl  <= cur_tgl;
                        have_prev <= 1'b1;
                        if (have_prev && (cur_tgl == prev_tgl)) begin
                            st <= S_FIN;
                        end else if (poll_cnt >= POLL_LAST) begin
                            tmo_q <= 1'b1;
                            st    <= S_FIN;
                        end else begin
                            gap_cnt <= GAP_LOAD;
                            st      <= S_GAP;
                        end
                    end
                end
                default: begin
                    st <= S_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/nor_seq_checker.sv
// Module: nor_seq_checker
// Protocol checks on the flash bus and the request/done interface of
// nor_seq_top. Bound to every instance of the top module below.
module nor_seq_checker #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done_valid,
    input logic              done_timeout,
    input logic              flash_ce_n,
    input logic              flash_we_n,
    input logic              flash_oe_n,
    input logic [ADDR_W-1:0] flash_addr,
    input logic [DATA_W-1:0] flash_dq_out,
    input logic              flash_dq_oe
);
    AST_WE_KEEPS_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> (flash_oe_n && flash_dq_oe)); // R4
    AST_WE_FALL_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_we_n) |-> ($past(!flash_ce_n) && !flash_ce_n)); // R4
    AST_WE_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n && !$past(flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_out))); // R4
    AST_READ_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> (!flash_ce_n && flash_we_n && !flash_dq_oe)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R6
    AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_timeout |-> done_valid); // R7
    AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (flash_ce_n && !flash_dq_oe)); // R8
endmodule

bind nor_seq_top nor_seq_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_nor_seq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .done_valid   (done_valid),
    .done_timeout (done_timeout),
    .flash_ce_n   (flash_ce_n),
    .flash_we_n   (flash_we_n),
    .flash_oe_n   (flash_oe_n),
    .flash_addr   (flash_addr),
    .flash_dq_out (flash_dq_out),
    .flash_dq_oe  (flash_dq_oe)
);

// File: tb/tb_nor_seq_top.sv
module tb_nor_seq_top;
    localparam int unsigned AW    = 19;
    localparam int unsigned DW    = 16;
    localparam int unsigned TS    = 2;
    localparam int unsigned TP    = 3;
    localparam int unsigned TH    = 1;
    localparam int unsigned TR    = 2;
    localparam int unsigned GAP   = 3;
    localparam int unsigned MAXP  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          done_valid;
    logic          done_timeout;
    logic          flash_ce_n;
    logic          flash_we_n;
    logic          flash_oe_n;
    logic [AW-1:0] flash_addr;
    logic [DW-1:0] flash_dq_out;
    logic          flash_dq_oe;
    logic [DW-1:0] flash_dq_in = '0;

    always #10 clk = ~clk;

    nor_seq_top #(
        .ADDR_W (AW), .DATA_W (DW), .T_SETUP (TS), .T_PULSE (TP),
        .T_HOLD (TH), .T_READ (TR), .POLL_GAP (GAP), .MAX_POLLS (MAXP)
    ) dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_op (req_op), .req_addr (req_addr), .req_data (req_data),
        .done_valid (done_valid), .done_timeout (done_timeout),
        .flash_ce_n (flash_ce_n), .flash_we_n (flash_we_n), .flash_oe_n (flash_oe_n),
        .flash_addr (flash_addr), .flash_dq_out (flash_dq_out),
        .flash_dq_oe (flash_dq_oe), .flash_dq_in (flash_dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    int        busy_left = 0;
    logic      tgl = 1'b0;
    logic [DW-1:0] final_val = '0;

    always @(negedge flash_oe_n) begin
        if (busy_left > 0) begin
            tgl = ~tgl;
            flash_dq_in = '0;
            flash_dq_in[6] = tgl;
            flash_dq_in[7] = ~final_val[7];
            busy_left = busy_left - 1;
        end else begin
            flash_dq_in = final_val;
        end
    end

    // ---------------- bus monitor (negedge samples) ----------------
    logic [AW-1:0] wr_a [16];
    logic [DW-1:0] wr_d [16];
    int            wr_len [16];
    int  n_wr = 0, n_rd = 0, unstable = 0, bad_wr = 0, bad_rd = 0;
    int  min_gap = 1000, ce_run = 0, last_run = 0, low_cnt = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1;
    logic [AW-1:0] fa = '0;
    logic [DW-1:0] fd = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!flash_we_n) begin
                if (prev_we) begin
                    low_cnt = 1; fa = flash_addr; fd = flash_dq_out;
                end else begin
                    low_cnt++;
                    if (flash_addr !== fa || flash_dq_out !== fd) unstable++;
                end
                if (!flash_oe_n || flash_ce_n || !flash_dq_oe) bad_wr++;
            end else if (!prev_we) begin
                if (n_wr < 16) begin
                    wr_a[n_wr] = fa; wr_d[n_wr] = fd; wr_len[n_wr] = low_cnt;
                end
                n_wr++;
            end
            if (!flash_oe_n) begin
                if (prev_oe) begin
                    n_rd++;
                    if (last_run < min_gap) min_gap = last_run;
                end
                if (flash_ce_n || !flash_we_n || flash_dq_oe) bad_rd++;
            end
            if (flash_ce_n) ce_run++;
            else if (prev_ce) begin last_run = ce_run; ce_run = 0; end
            prev_we = flash_we_n; prev_oe = flash_oe_n; prev_ce = flash_ce_n;
        end
    end

    // ---------------- expectation helpers ----------------
    function automatic void exp_wr(input int op, input int k, input logic [AW-1:0] a,
                                   input logic [DW-1:0] d,
                                   output logic [AW-1:0] ea, output logic [DW-1:0] ed);
        case (k)
            0: begin ea = 19'h05555; ed = 16'h00AA; end
            1: begin ea = 19'h02AAA; ed = 16'h0055; end
            2: begin ea = 19'h05555; ed = (op == 0) ? 16'h00A0 : 16'h0080; end
            3: begin
                if (op == 0) begin ea = a; ed = d; end
                else begin ea = 19'h05555; ed = 16'h00AA; end
            end
            4: begin ea = 19'h02AAA; ed = 16'h0055; end
            default: begin
                if (op == 1) begin ea = a; ed = 16'h0030; end
                else if (op == 2) begin ea = a; ed = 16'h0050; end
                else begin ea = 19'h05555; ed = 16'h0010; end
            end
        endcase
    endfunction

    function automatic int exp_reads(input int busy, input logic b6, output logic tmo);
        logic prev = 1'b0;
        for (int k = 0; k < 64; k++) begin
            logic cur;
            cur = (k < busy) ? ((k % 2) == 0) : b6;
            if (k > 0 && cur == prev) begin
                tmo = 1'b0;
                return k + 1;
            end
            if (k + 1 >= MAXP) begin
                tmo = 1'b1;
                return MAXP;
            end
            prev = cur;
        end
        tmo = 1'b1;
        return MAXP;
    endfunction

    // ---------------- scenario engine ----------------
    task automatic run_op(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int busy, input logic [DW-1:0] fin, input bit stall,
                          input string tag);
        logic exp_tmo;
        int   exp_rd;
        int   exp_nwr;
        bit   seen = 0;
        logic got_tmo = 1'b0;
        string rq_done;
        exp_rd  = exp_reads(busy, fin[6], exp_tmo);
        exp_nwr = (op == 0) ? 4 : 6;
        rq_done = exp_tmo ? "R7" : "R6";
        @(negedge clk);
        n_wr = 0; n_rd = 0; unstable = 0; bad_wr = 0; bad_rd = 0; min_gap = 1000;
        busy_left = busy; tgl = 1'b0; final_val = fin;
        chk("R8", {tag, " ready before request"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 3000 && !seen; t++) begin
            @(negedge clk);
            if (stall && t >= 8 && t < 13) begin
                req_valid = 1'b1; req_op = 2'd3; req_addr = '1;
                chk("R8", {tag, " ready low while busy"}, 32'(req_ready), 32'd0);
            end else begin
                req_valid = 1'b0;
            end
            if (done_valid) begin
                seen = 1; got_tmo = done_timeout;
            end
        end
        req_valid = 1'b0;
        chk(rq_done, {tag, " done pulse seen"}, 32'(seen), 32'd1);
        @(negedge clk);
        chk(rq_done, {tag, " done is one cycle"}, 32'(done_valid), 32'd0);
        repeat (20) @(negedge clk);
        chk(rq_done, {tag, " timeout flag"}, 32'(got_tmo), 32'(exp_tmo));
        chk(op == 0 ? "R2" : "R3", {tag, " write count (R9 no late writes)"},
            32'(n_wr), 32'(exp_nwr));
        for (int k = 0; k < exp_nwr && k < n_wr; k++) begin
            logic [AW-1:0] ea;
            logic [DW-1:0] ed;
            exp_wr(op, k, a, d, ea, ed);
            chk(op == 0 ? "R2" : "R3", $sformatf("%s write %0d address", tag, k),
                32'(wr_a[k]), 32'(ea));
            chk(op == 0 ? "R2" : "R3", $sformatf("%s write %0d data", tag, k),
                32'(wr_d[k]), 32'(ed));
            chk("R4", $sformatf("%s write %0d WE low clocks", tag, k),
                32'(wr_len[k]), 32'(TP));
        end
        chk("R4", {tag, " address/data unstable samples"}, 32'(unstable), 32'd0);
        chk("R4", {tag, " strobe violations in writes"}, 32'(bad_wr), 32'd0);
        chk("R5", {tag, " strobe violations in reads"}, 32'(bad_rd), 32'd0);
        chk(rq_done, {tag, " status read count"}, 32'(n_rd), 32'(exp_rd));
        chk("R6", {tag, " CE-high gap before reads ok"}, 32'(min_gap >= int'(GAP)), 32'd1);
        chk("R8", {tag, " ready and bus idle after done"},
            32'({req_ready, flash_ce_n}), 32'b11);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "ready in reset", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "strobes after reset", 32'({flash_ce_n, flash_we_n, flash_oe_n}), 32'b111);
        chk("R1", "data driver after reset", 32'(flash_dq_oe), 32'd0);
        chk("R1", "done after reset", 32'(done_valid), 32'd0);
        chk("R1", "ready after reset", 32'(req_ready), 32'd1);
    endtask

    task automatic t_program();
        run_op(0, 19'h1_2345, 16'h1234, 3, 16'h1234, 0, "R2 program b6=0");
        run_op(0, 19'h7_FFFF, 16'hC3C3, 1, 16'hC3C3, 0, "R2 program b6=1");
    endtask

    task automatic t_sector();
        run_op(1, 19'h0_4800, 16'h0000, 2, 16'hFFFF, 0, "R3 sector erase");
    endtask

    task automatic t_block();
        run_op(2, 19'h4_0000, 16'h0000, 4, 16'hFFFF, 0, "R3 block erase");
    endtask

    task automatic t_chip();
        run_op(3, 19'h0_0000, 16'h0000, 0, 16'hFFFF, 0, "R3 chip erase");
    endtask

    task automatic t_timeout();
        run_op(0, 19'h0_0101, 16'hA5A5, 20, 16'hA5A5, 0, "R7 stuck busy");
    endtask

    task automatic t_stall();
        run_op(3, 19'h0_0000, 16'h0000, 3, 16'hFFFF, 1, "R8 stall chip erase");
    endtask

    initial begin : watchdog
        while (cyc < 150000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog expired actual=%0d expected<%0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_program();
        t_sector();
        t_block();
        t_chip();
        t_timeout();
        t_stall();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule